// File: doc/BRIEF.md
# Slow-Clock Counter with Compare Interrupt

This block keeps a 32-bit free-running count advanced by a slow clock, normally a 32.768 kHz source, and lets a register bus in a fast system clock domain observe and steer it. The bus can read a tear-free copy of the live count. It can load a new count, set a prescaler that stretches each count step over several slow edges, and program a compare value. When the counter steps onto the compare value, the block raises a level interrupt in the fast domain. A common use is a one-shot event: read the count, then write compare = count + delta.

Each write to a slow-domain register is held in the fast domain and handed across with a toggle handshake. A per-register busy bit in the control word stays set until the slow side has applied the value and its acknowledge has come back. The control word also holds the enable bit for the slow counter and a sticky flag that records that the slow clock has ever ticked. The total crossing time is short enough that a delta of 9 slow ticks still produces an event.

Top module: `slow_match_timer`

## Requirements
- R1: The count is 32 bits wide, steps by one and wraps from 0xFFFFFFFF to 0.
- R2: With a prescale value of 0 at address 1, the count advances on every slow-clock rising edge; with a value N > 0 it advances once every N+1 slow edges.
- R3: A write to address 2 replaces the count with the written value once the load crossing completes; reads of address 2 return the count.
- R4: The control word at address 0 has busy bits at bit 2 (prescale), bit 3 (count load) and bit 4 (compare); an accepted write sets only its own bit, visible on the next bus cycle.
- R5: A write to a register whose busy bit is set is ignored; once the bit clears a new write is accepted. Addresses 1 and 3 read back the last accepted value.
- R6: Bit 0 of the control word enables the counter. While it is 0 the count holds and writes to addresses 1, 2 and 3 are ignored (no busy bit sets, no value changes).
- R7: Bit 1 of the control word reads 0 until the first slow-clock edge after reset, then reads 1 and stays 1 even if the slow clock stops.
- R8: When the counter steps onto the compare value, bit 5 of the control word and the irq output go to 1 and stay there until a control write with bit 5 set clears them; a new event wins over a clear in the same cycle.
- R9: Each busy bit clears within five slow-clock periods of its write, so a compare written as count + 9 still fires.
- R10: Successive reads of the count while it runs with prescale 0 never differ by more than one step (no torn value).
- R11: After reset every register reads 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| sclk | input | 1 | Slow counting clock |
| bus_wr | input | 1 | Write strobe, one fast cycle per write |
| bus_addr | input | 2 | Register address: 0 control, 1 prescale, 2 count, 3 compare |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| irq | output | 1 | Compare event flag, level |

## Verification
On every cycle the embedded properties check the wrap from all-ones to zero, that a load lands on the next slow edge, that the count holds while disabled or between prescaled steps, and that a compare toggle happens only with the count equal to the compare value. They also check that an accepted write raises its busy bit, that a refused write leaves the held value alone, that nothing goes busy while the enable is off, and that the clock-detected and event flags behave as set/clear latches. The rate set by the prescaler, the crossing latency against the 9-tick minimum, the tear-free reads, and the end-to-end match from a bus write to irq can only be shown by the bench's timed scenarios.

// File: rtl/smt_pkg.sv
package smt_pkg;

  localparam int SMT_CNT_W  = 32;
  localparam int SMT_TRIM_W = 16;
  localparam int SMT_SYNC   = 2;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_TRIM  = 2'd1,
    REG_COUNT = 2'd2,
    REG_MATCH = 2'd3
  } smt_reg_e;

  // slow-domain write slots, each with its own crossing
  localparam int NSLOT      = 3;
  localparam int SLOT_TRIM  = 0;
  localparam int SLOT_LOAD  = 1;
  localparam int SLOT_MATCH = 2;

  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_DET  = 1;
  localparam int CB_BUSY = 2;
  localparam int CB_FLAG = CB_BUSY + NSLOT;
  localparam int CTRL_W  = CB_FLAG + 1;

  function automatic logic [1:0] slot_addr(int slot);
    case (slot)
      SLOT_TRIM: return REG_TRIM;
      SLOT_LOAD: return REG_COUNT;
      default:   return REG_MATCH;
    endcase
  endfunction

  // prescaler: a step is due once the phase has reached the trim value
  function automatic logic tick_due(logic [31:0] phase, logic [31:0] trim);
    return phase >= trim;
  endfunction

  function automatic logic [CTRL_W-1:0] pack_ctrl(logic en, logic det,
                                                  logic [NSLOT-1:0] busy,
                                                  logic flag);
    return {flag, busy, det, en};
  endfunction

endpackage

// File: rtl/smt_sync.sv
module smt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/smt_wr_xing.sv
module smt_wr_xing #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         sclk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  output logic         busy,
  output logic [W-1:0] hold_q,
  output logic         s_apply
);

  logic req_tog;
  logic req_s;
  logic ack_s;
  logic ack_f;
  logic take;

  assign take = wr_req && !busy;

  // fast side: value is held stable until the acknowledge returns
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tog <= 1'b0;
      hold_q  <= '0;
    end else if (take) begin
      req_tog <= ~req_tog;
      hold_q  <= wdata;
    end
  end

  smt_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
    .clk   (sclk),
    .rst_n (rst_n),
    .d     (req_tog),
    .q     (req_s)
  );

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) ack_s <= 1'b0;
    else        ack_s <= req_s;
  end

  assign s_apply = req_s ^ ack_s;

  smt_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_s),
    .q     (ack_f)
  );

  assign busy = req_tog ^ ack_f;

  // R4: an accepted write is pending on the next cycle
  p_busy_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy);

  // R5: a write arriving while pending leaves the held value untouched
  p_hold_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && busy) |=> $stable(hold_q));

  // R5: the slow side only applies while the fast side still reports busy
  p_apply_in_flight_r5: assert property (@(posedge sclk) disable iff (!rst_n)
    s_apply |-> (req_tog != ack_s));

endmodule

// File: rtl/smt_slow_core.sv
module smt_slow_core
  import smt_pkg::*;
#(
  parameter int CNT_W  = SMT_CNT_W,
  parameter int TRIM_W = SMT_TRIM_W,
  parameter int STAGES = SMT_SYNC
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              en_in,
  input  logic              trim_apply,
  input  logic [TRIM_W-1:0] trim_d,
  input  logic              load_apply,
  input  logic [CNT_W-1:0]  load_d,
  input  logic              match_apply,
  input  logic [CNT_W-1:0]  match_d,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              snap_tog,
  output logic              match_tog,
  output logic              det_q
);

  logic              en_s;
  logic [TRIM_W-1:0] trim_q;
  logic [TRIM_W-1:0] phase_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]  cnt_inc;
  logic              tick;
  logic              hit;

  smt_sync #(.W(1), .STAGES(STAGES)) u_en_sync (
    .clk   (sclk),
    .rst_n (rst_n),
    .d     (en_in),
    .q     (en_s)
  );

  assign tick    = en_s && tick_due(32'(phase_q), 32'(trim_q));
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit     = tick && !load_apply && (cnt_inc == cmp_q);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q    <= '0;
      phase_q   <= '0;
      cmp_q     <= '0;
      cnt_q     <= '0;
      snap_tog  <= 1'b0;
      match_tog <= 1'b0;
      det_q     <= 1'b0;
    end else begin
      det_q    <= 1'b1;
      snap_tog <= ~snap_tog;
      if (trim_apply)  trim_q <= trim_d;
      if (match_apply) cmp_q  <= match_d;
      if (en_s)        phase_q <= tick ? '0 : phase_q + TRIM_W'(1);
      if (load_apply)  cnt_q <= load_d;
      else if (tick)   cnt_q <= cnt_inc;
      if (hit)         match_tog <= ~match_tog;
    end
  end

  // R1: all-ones steps to zero
  p_wrap_r1: assert property (@(posedge sclk) disable iff (!rst_n)
    (tick && !load_apply && cnt_q == '1) |=> cnt_q == '0);

  // R3: a load lands on the next slow edge
  p_load_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    load_apply |=> cnt_q == $past(load_d));

  // R6: disabled counter holds
  p_hold_disabled_r6: assert property (@(posedge sclk) disable iff (!rst_n)
    (!en_s && !load_apply) |=> $stable(cnt_q));

  // R2: between prescaled steps the count holds
  p_presc_hold_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    (phase_q < trim_q && !load_apply) |=> $stable(cnt_q));

  // R8: an event toggle only happens with the count on the compare value
  p_match_equal_r8: assert property (@(posedge sclk) disable iff (!rst_n)
    (!$stable(match_tog) && !$past(match_apply)) |-> cnt_q == cmp_q);

endmodule

// File: rtl/slow_match_timer.sv
module slow_match_timer
  import smt_pkg::*;
#(
  parameter int CNT_W    = SMT_CNT_W,
  parameter int TRIM_W   = SMT_TRIM_W,
  parameter int SYNC_STG = SMT_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);

  logic              en_q;
  logic              flag_q;
  logic              det_q;
  logic [CNT_W-1:0]  view_q;

  logic [NSLOT-1:0]  wr_req;
  logic [NSLOT-1:0]  busy_v;
  logic [NSLOT-1:0]  apply_v;
  logic [TRIM_W-1:0] trim_hold;
  logic [CNT_W-1:0]  load_hold;
  logic [CNT_W-1:0]  match_hold;

  logic [CNT_W-1:0]  cnt_s;
  logic              snap_tog_s;
  logic              match_tog_s;
  logic              det_s;
  logic              snap_f;
  logic              match_f;
  logic              det_f;
  logic              snap_f_d;
  logic              match_f_d;

  // named events for the assertions
  logic              ctrl_wr;
  logic              flag_clr;
  logic              snap_evt;
  logic              match_evt;

  assign ctrl_wr   = bus_wr && (bus_addr == REG_CTRL);
  assign flag_clr  = ctrl_wr && bus_wdata[CB_FLAG];
  assign snap_evt  = snap_f ^ snap_f_d;
  assign match_evt = match_f ^ match_f_d;

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_xing
    localparam int XW = (gi == SLOT_TRIM) ? TRIM_W : CNT_W;
    logic [XW-1:0] hold;

    assign wr_req[gi] = bus_wr && en_q && (bus_addr == slot_addr(gi));

    smt_wr_xing #(.W(XW), .STAGES(SYNC_STG)) u_xing (
      .clk     (clk),
      .sclk    (sclk),
      .rst_n   (rst_n),
      .wr_req  (wr_req[gi]),
      .wdata   (bus_wdata[XW-1:0]),
      .busy    (busy_v[gi]),
      .hold_q  (hold),
      .s_apply (apply_v[gi])
    );

    if (gi == SLOT_TRIM) begin : g_trim
      assign trim_hold = hold;
    end else if (gi == SLOT_LOAD) begin : g_load
      assign load_hold = hold;
    end else begin : g_match
      assign match_hold = hold;
    end
  end

  smt_slow_core #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .STAGES(SYNC_STG)) u_core (
    .sclk        (sclk),
    .rst_n       (rst_n),
    .en_in       (en_q),
    .trim_apply  (apply_v[SLOT_TRIM]),
    .trim_d      (trim_hold),
    .load_apply  (apply_v[SLOT_LOAD]),
    .load_d      (load_hold),
    .match_apply (apply_v[SLOT_MATCH]),
    .match_d     (match_hold),
    .cnt_q       (cnt_s),
    .snap_tog    (snap_tog_s),
    .match_tog   (match_tog_s),
    .det_q       (det_s)
  );

  smt_sync #(.W(3), .STAGES(SYNC_STG)) u_back_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({det_s, match_tog_s, snap_tog_s}),
    .q     ({det_f, match_f, snap_f})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      flag_q    <= 1'b0;
      det_q     <= 1'b0;
      snap_f_d  <= 1'b0;
      match_f_d <= 1'b0;
      view_q    <= '0;
    end else begin
      snap_f_d  <= snap_f;
      match_f_d <= match_f;
      det_q     <= det_q | det_f;
      if (ctrl_wr)   en_q   <= bus_wdata[CB_EN];
      // the slow count is stable for a whole slow period after its toggle
      if (snap_evt)  view_q <= cnt_s;
      if (match_evt)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      REG_CTRL:  bus_rdata = CNT_W'(pack_ctrl(en_q, det_q, busy_v, flag_q));
      REG_TRIM:  bus_rdata = CNT_W'(trim_hold);
      REG_COUNT: bus_rdata = view_q;
      default:   bus_rdata = match_hold;
    endcase
  end

  assign irq = flag_q;

  // R7: clock-detected is sticky
  p_det_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |=> det_q);

  // R8: an event sets the flag, winning over a clear
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_q);

  // R8: a clear without an event drops the flag
  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match_evt) |=> !flag_q);

  // R6: nothing goes in flight while the enable is off
  p_no_pending_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && busy_v == '0) |=> busy_v == '0);

  // R4: only one slot can become pending per bus write
  p_one_new_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_v == '0) |=> $countones(busy_v) <= 1);

endmodule

// File: tb/slow_match_timer_tb.sv
module slow_match_timer_tb;

  localparam logic [1:0] A_CTRL = 2'd0, A_TRIM = 2'd1, A_COUNT = 2'd2, A_MATCH = 2'd3;
  localparam int B_EN = 0, B_DET = 1, B_TRIM = 2, B_LOAD = 3, B_MATCH = 4, B_FLAG = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sclk_run = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;
  always begin
    #48;
    if (sclk_run) sclk = ~sclk;
  end

  slow_match_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  function automatic int exp_steps(int edges, int trim);
    return edges / (trim + 1);
  endfunction

  function automatic logic [31:0] busy_mask(int slot);
    return 32'(1) << (B_TRIM + slot);
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_clear(input int bitn, input string req);
    logic [31:0] v;
    int n;
    for (n = 0; n < 80; n++) begin
      rd(A_CTRL, v);
      if (!v[bitn]) break;
    end
    check(n <= 60, req, 32'(n), 32'd60);
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(posedge sclk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, c, c0, c1, a, b, prev, exp_v;
    int bad;
    void'($urandom(32'd4242));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    rd(A_CTRL, v);  check(v == 0, "R11 ctrl", v, 0);
    rd(A_TRIM, v);  check(v == 0, "R11 trim", v, 0);
    rd(A_COUNT, v); check(v == 0, "R11 count", v, 0);
    rd(A_MATCH, v); check(v == 0, "R11 match", v, 0);
    check(irq == 1'b0, "R11 irq", 32'(irq), 0);

    // R7: no detect before the slow clock runs
    repeat (20) @(negedge clk);
    rd(A_CTRL, v); check(v[B_DET] == 1'b0, "R7 no edge yet", v, 0);

    wr(A_CTRL, 32'h1);
    sclk_run = 1'b1;
    wait_slow(3);
    rd(A_CTRL, v); check(v[B_DET] && v[B_EN], "R7 detected", v, 32'h3);

    // R4/R5/R9: per-slot busy bits and readback
    for (int it = 0; it < 6; it++) begin
      int slot = int'($urandom % 3);
      logic [1:0] a_s = (slot == 0) ? A_TRIM : (slot == 1) ? A_COUNT : A_MATCH;
      logic [31:0] d = (slot == 0) ? 32'd0 : $urandom;
      wr(a_s, d);
      rd(A_CTRL, v);
      check((v & 32'h1C) == busy_mask(slot), "R4 busy bit", v & 32'h1C, busy_mask(slot));
      wait_clear(B_TRIM + slot, "R9 busy clears");
      if (slot != 1) begin
        rd(a_s, v); check(v == d, "R5 readback", v, d);
      end
    end

    // R5/R8/R9: refused second write, delta of 9 ticks
    wr(A_CTRL, 32'h21);
    rd(A_COUNT, c);
    wr(A_MATCH, c + 32'd9);
    wr(A_MATCH, c + 32'd5000);
    rd(A_MATCH, v); check(v == c + 32'd9, "R5 write while busy ignored", v, c + 32'd9);
    wait_clear(B_MATCH, "R9 match busy clears");
    check(irq == 1'b0, "R8 no early event", 32'(irq), 0);
    wait_slow(15);
    rd(A_CTRL, v); check(v[B_FLAG] == 1'b1, "R9 delta 9 fires", v, 32'h21);
    check(irq == 1'b1, "R8 irq high", 32'(irq), 1);
    wr(A_MATCH, c + 32'd100000);
    rd(A_CTRL, v); check(v[B_MATCH] == 1'b1, "R5 accepted after clear", v, 32'h10);
    wait_clear(B_MATCH, "R9 match busy clears");
    wr(A_CTRL, 32'h1);
    check(irq == 1'b1, "R8 flag holds without clear", 32'(irq), 1);
    wr(A_CTRL, 32'h21);
    rd(A_CTRL, v); check(v[B_FLAG] == 1'b0 && irq == 1'b0, "R8 write-one clear", v, 32'h1);

    // R3: loads
    for (int it = 0; it < 3; it++) begin
      logic [31:0] ld = (it == 0) ? 32'd0 : ($urandom & 32'h7FFF_FFFF);
      wr(A_COUNT, ld);
      wait_clear(B_LOAD, "R9 load busy clears");
      wait_slow(2);
      rd(A_COUNT, v); check((v - ld) <= 32'd4, "R3 load value", v, ld);
    end

    // R1: wrap
    wr(A_COUNT, 32'hFFFF_FFFA);
    wait_clear(B_LOAD, "R9 load busy clears");
    wait_slow(12);
    rd(A_COUNT, v); check(v < 32'd16, "R1 wrap to zero", v, 32'd8);

    // R10: tear-free reads across a wrap
    wr(A_COUNT, 32'hFFFF_FFF0);
    wait_clear(B_LOAD, "R9 load busy clears");
    wait_slow(2);
    rd(A_COUNT, prev);
    bad = 0;
    for (int i = 0; i < 400; i++) begin
      rd(A_COUNT, v);
      if ((v - prev) > 32'd1) bad++;
      prev = v;
    end
    check(bad == 0, "R10 successive reads", 32'(bad), 0);

    // R2: prescaler
    for (int it = 0; it < 5; it++) begin
      int t = (it == 0) ? 0 : 1 + int'($urandom % 6);
      int d;
      wr(A_TRIM, 32'(t));
      wait_clear(B_TRIM, "R9 trim busy clears");
      wr(A_COUNT, 32'd0);
      wait_clear(B_LOAD, "R9 load busy clears");
      wait_slow(2);
      rd(A_COUNT, c0);
      wait_slow(60);
      rd(A_COUNT, c1);
      d = int'(c1 - c0);
      exp_v = 32'(exp_steps(60, t));
      check(d >= exp_steps(60, t) - 2 && d <= exp_steps(60, t) + 2,
            "R2 prescaled rate", 32'(d), exp_v);
    end
    wr(A_TRIM, 32'd0);
    wait_clear(B_TRIM, "R9 trim busy clears");

    // R6: disable
    rd(A_MATCH, b);
    wr(A_CTRL, 32'h0);
    wait_slow(4);
    rd(A_COUNT, a);
    wait_slow(10);
    rd(A_COUNT, v); check(v == a, "R6 count holds", v, a);
    wr(A_COUNT, 32'h1234);
    rd(A_CTRL, v); check((v & 32'h1C) == 0, "R6 load ignored no busy", v, 0);
    wr(A_MATCH, 32'h5555);
    rd(A_MATCH, v); check(v == b, "R6 match write ignored", v, b);
    wait_slow(4);
    rd(A_COUNT, v); check(v == a, "R6 load had no effect", v, a);
    wr(A_CTRL, 32'h1);
    wait_slow(6);
    rd(A_COUNT, v); check(v != a, "R6 resumes when enabled", v, a + 32'd3);

    // R7: sticky after the slow clock stops
    sclk_run = 1'b0;
    repeat (40) @(negedge clk);
    rd(A_CTRL, v); check(v[B_DET] == 1'b1, "R7 sticky", v, 32'h3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule